// File: doc/BRIEF.md
# Masked Vector Execution Unit

This unit executes one vector instruction at a time, one element per cycle, under a per-element predicate mask. It reads two operand elements from an external vector register file through a shared index, computes an integer sum, a truncated product or a greater-than test, and returns results through a write port whose enable reflects the mask. The mask register lives inside the unit. A compare instruction loads it, a clear instruction sets every bit, and its contents are visible on an output.

The unit has two execution styles. In the full-pass style every element below the vector length takes one cycle, and elements whose mask bit is zero are still computed but not written. In the skipping style a priority scan finds the next enabled element, so a sparse mask finishes in proportionally fewer cycles. The surrounding pipeline raises `start_i` for one cycle with the instruction fields, then waits for the one-cycle `done_o` pulse.

Top module: `mve_unit`

## Requirements
- R1: After reset `done_o`, `wr_en_o` and `busy_o` are 0 and every bit of `mask_o` is 1.
- R2: For op code 0 (add) and 1 (multiply, low DW bits of the product), each element i below the vector length with mask bit i set gets `a[i] op b[i]` written at index i. An element whose mask bit is 0 is never written, so its destination keeps its old value.
- R3: Mode 1 (skip) produces exactly the same set of writes and data as mode 0 (full pass) for the same mask, operands and length.
- R4: In mode 0, counting the clock edge that accepts `start_i` as edge 1, `done_o` is high after edge vlen+2. This includes vlen = 0.
- R5: In mode 1 with k enabled mask bits below the vector length, `done_o` is high after edge k+2. With no enabled bit this is edge 2, and nothing is written.
- R6: Op code 2 sets mask bit i, for every i below the vector length, to the signed test a[i] > scalar. Bits at or above the length are kept. It writes nothing to the register file and always uses the mode 0 timing.
- R7: Op code 3 sets every mask bit to 1, writes nothing, and pulses `done_o` after edge 1.
- R8: Within one instruction, writes come out in strictly increasing index order, and every written index is below the vector length.
- R9: While `busy_o` is high, `start_i` is ignored: the mask and the running instruction's results and timing are unaffected.
- R10: `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch an instruction (accepted only when idle) |
| op_i | input | 2 | 0 add, 1 multiply, 2 compare greater-than, 3 set mask to all ones |
| mode_i | input | 1 | 0 full pass, 1 skip masked-off elements |
| vlen_i | input | IDX_W+1 | Vector length, 0 to VLMAX |
| scalar_i | input | DW | Scalar operand for the compare |
| rd_idx_o | output | IDX_W | Element index presented to the register file read ports |
| rd_a_i | input | DW | First operand element at `rd_idx_o` (same-cycle read) |
| rd_b_i | input | DW | Second operand element at `rd_idx_o` (same-cycle read) |
| wr_en_o | output | 1 | Result write enable |
| wr_idx_o | output | IDX_W | Result element index |
| wr_data_o | output | DW | Result element data |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mask_o | output | VLMAX | Current mask register |

## Verification
The assertions assume that `vlen_i` never exceeds VLMAX, and that the read ports return the addressed element combinationally in the same cycle. They also assume the operand contents do not change while an instruction runs. The bench models the register file as arrays indexed by `rd_idx_o` and only changes them between instructions. It draws lengths from 0 to VLMAX and raises `start_i` during a run only in the dedicated test of R9.

// File: rtl/mve_pkg.sv
package mve_pkg;
   typedef enum logic [1:0] {
      OP_ADD    = 2'd0,
      OP_MUL    = 2'd1,
      OP_CMPGT  = 2'd2,
      OP_SETALL = 2'd3
   } op_e;

   typedef enum logic {
      MD_FULL = 1'b0,
      MD_SKIP = 1'b1
   } mode_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } state_e;
endpackage

// File: rtl/mve_scan.sv
module mve_scan #(
   parameter int VLMAX = 16,
   parameter int IDX_W = 4,
   parameter int LEN_W = 5
) (
   input  logic [VLMAX-1:0] mask,
   input  logic [LEN_W-1:0] from,
   input  logic [LEN_W-1:0] lim,
   output logic [IDX_W-1:0] idx,
   output logic             found
);
   logic [VLMAX-1:0] elig;

   for (genvar g = 0; g < VLMAX; g++) begin : g_elig
      assign elig[g] = mask[g] && (LEN_W'(g) >= from) && (LEN_W'(g) < lim);
   end

   always_comb begin
      idx = '0;
      for (int i = VLMAX - 1; i >= 0; i--) begin
         if (elig[i]) idx = IDX_W'(i);
      end
   end

   assign found = |elig;
endmodule

// File: rtl/mve_alu.sv
module mve_alu #(
   parameter int DW         = 16,
   parameter bit CMP_SIGNED = 1'b1
) (
   input  mve_pkg::op_e  op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [DW-1:0] scalar,
   output logic [DW-1:0] res,
   output logic          gt
);
   import mve_pkg::*;
   logic [2*DW-1:0] prod;

   assign prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};

   always_comb begin
      case (op)
         OP_MUL:  res = prod[DW-1:0];
         default: res = a + b;
      endcase
   end

   if (CMP_SIGNED) begin : g_cmp_s
      assign gt = $signed(a) > $signed(scalar);
   end else begin : g_cmp_u
      assign gt = a > scalar;
   end
endmodule

// File: rtl/mve_mask.sv
module mve_mask #(
   parameter int VLMAX = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_all,
   input  logic             upd,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_bit,
   output logic [VLMAX-1:0] mask
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= '1;
      end else if (set_all) begin
         mask <= '1;
      end else if (upd) begin
         mask[upd_idx] <= upd_bit;
      end
   end
endmodule

// File: rtl/mve_unit.sv
module mve_unit #(
   parameter int VLMAX      = 16,
   parameter int DW         = 16,
   parameter bit CMP_SIGNED = 1'b1,
   localparam int IDX_W     = (VLMAX > 1) ? $clog2(VLMAX) : 1,
   localparam int LEN_W     = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       op_i,
   input  logic             mode_i,
   input  logic [LEN_W-1:0] vlen_i,
   input  logic [DW-1:0]    scalar_i,
   output logic [IDX_W-1:0] rd_idx_o,
   input  logic [DW-1:0]    rd_a_i,
   input  logic [DW-1:0]    rd_b_i,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] wr_idx_o,
   output logic [DW-1:0]    wr_data_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [VLMAX-1:0] mask_o
);
   import mve_pkg::*;

   if (VLMAX < 2) begin : g_bad_len
      $error("mve_unit: VLMAX must be at least 2");
   end
   if (DW < 2) begin : g_bad_dw
      $error("mve_unit: DW must be at least 2");
   end

   state_e           state;
   op_e              op_q;
   mode_e            mode_q;
   logic [LEN_W-1:0] vlen_q;
   logic [DW-1:0]    scal_q;
   logic [LEN_W-1:0] cur_q;
   logic             wr_en_q;
   logic [IDX_W-1:0] wr_idx_q;
   logic [DW-1:0]    wr_data_q;
   logic             done_q;

   logic             accept;
   logic             skipping;
   logic [IDX_W-1:0] scan_idx;
   logic             scan_found;
   logic [IDX_W-1:0] elem_idx;
   logic             issue;
   logic [DW-1:0]    alu_res;
   logic             alu_gt;
   logic             mask_upd;

   assign accept   = (state == ST_IDLE) && start_i;
   assign skipping = (mode_q == MD_SKIP) && (op_q != OP_CMPGT);

   mve_scan #(.VLMAX(VLMAX), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_scan (
      .mask  (mask_o),
      .from  (cur_q),
      .lim   (vlen_q),
      .idx   (scan_idx),
      .found (scan_found)
   );

   assign elem_idx = skipping ? scan_idx : cur_q[IDX_W-1:0];
   assign issue    = skipping ? scan_found : (cur_q < vlen_q);
   assign rd_idx_o = elem_idx;

   mve_alu #(.DW(DW), .CMP_SIGNED(CMP_SIGNED)) u_alu (
      .op     (op_q),
      .a      (rd_a_i),
      .b      (rd_b_i),
      .scalar (scal_q),
      .res    (alu_res),
      .gt     (alu_gt)
   );

   assign mask_upd = (state == ST_RUN) && issue && (op_q == OP_CMPGT);

   mve_mask #(.VLMAX(VLMAX), .IDX_W(IDX_W)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_all (accept && (op_e'(op_i) == OP_SETALL)),
      .upd     (mask_upd),
      .upd_idx (elem_idx),
      .upd_bit (alu_gt),
      .mask    (mask_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         op_q      <= OP_ADD;
         mode_q    <= MD_FULL;
         vlen_q    <= '0;
         scal_q    <= '0;
         cur_q     <= '0;
         wr_en_q   <= 1'b0;
         wr_idx_q  <= '0;
         wr_data_q <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         wr_en_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  if (op_e'(op_i) == OP_SETALL) begin
                     done_q <= 1'b1;
                  end else begin
                     state  <= ST_RUN;
                     op_q   <= op_e'(op_i);
                     mode_q <= mode_e'(mode_i);
                     vlen_q <= vlen_i;
                     scal_q <= scalar_i;
                     cur_q  <= '0;
                  end
               end
            end
            ST_RUN: begin
               if (issue) begin
                  cur_q <= LEN_W'(elem_idx) + LEN_W'(1);
                  if (op_q != OP_CMPGT) begin
                     wr_en_q   <= mask_o[elem_idx];
                     wr_idx_q  <= elem_idx;
                     wr_data_q <= alu_res;
                  end
               end else begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign wr_en_o   = wr_en_q;
   assign wr_idx_o  = wr_idx_q;
   assign wr_data_o = wr_data_q;
   assign busy_o    = (state == ST_RUN);
   assign done_o    = done_q;
endmodule

// File: rtl/mve_unit_chk.sv
module mve_unit_chk #(
   parameter int VLMAX = 16,
   parameter int IDX_W = 4,
   parameter int LEN_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             accept,
   input mve_pkg::op_e     op_q,
   input logic [LEN_W-1:0] vlen_q,
   input logic             wr_en_o,
   input logic [IDX_W-1:0] wr_idx_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [VLMAX-1:0] mask_o
);
   import mve_pkg::*;

   logic             have_last;
   logic [IDX_W-1:0] last_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_last <= 1'b0;
         last_idx  <= '0;
      end else if (accept) begin
         have_last <= 1'b0;
      end else if (wr_en_o) begin
         have_last <= 1'b1;
         last_idx  <= wr_idx_o;
      end
   end

   AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (LEN_W'(wr_idx_o) < vlen_q)); // R8
   AST_WR_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && have_last) |-> (wr_idx_o > last_idx)); // R8
   AST_WR_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> mask_o[wr_idx_o]); // R2
   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && (op_q == OP_CMPGT)) |-> !wr_en_o); // R6
   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !wr_en_o); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R10
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(op_q)); // R9
endmodule

bind mve_unit mve_unit_chk #(.VLMAX(VLMAX), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .accept   (accept),
   .op_q     (op_q),
   .vlen_q   (vlen_q),
   .wr_en_o  (wr_en_o),
   .wr_idx_o (wr_idx_o),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .mask_o   (mask_o)
);

// File: tb/mve_unit_bench.sv
`timescale 1ns/1ps
module mve_unit_bench;
   localparam int VLMAX = 16;
   localparam int DW    = 16;
   localparam int IDX_W = 4;
   localparam int LEN_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [1:0]       op_i = 2'd0;
   logic             mode_i = 1'b0;
   logic [LEN_W-1:0] vlen_i = '0;
   logic [DW-1:0]    scalar_i = '0;
   logic [IDX_W-1:0] rd_idx_o;
   logic [DW-1:0]    rd_a_i, rd_b_i;
   logic             wr_en_o;
   logic [IDX_W-1:0] wr_idx_o;
   logic [DW-1:0]    wr_data_o;
   logic             busy_o, done_o;
   logic [VLMAX-1:0] mask_o;

   logic [DW-1:0]    va [VLMAX];
   logic [DW-1:0]    vb [VLMAX];
   logic [DW-1:0]    vc [VLMAX];
   logic [VLMAX-1:0] model_mask;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   assign rd_a_i = va[rd_idx_o];
   assign rd_b_i = vb[rd_idx_o];

   mve_unit #(.VLMAX(VLMAX), .DW(DW)) u_mve_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .mode_i(mode_i),
      .vlen_i(vlen_i), .scalar_i(scalar_i), .rd_idx_o(rd_idx_o), .rd_a_i(rd_a_i),
      .rd_b_i(rd_b_i), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
      .busy_o(busy_o), .done_o(done_o), .mask_o(mask_o)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] ref_op(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
      logic [2*DW-1:0] p;
      p = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
      return (op == 1) ? p[DW-1:0] : a + b;
   endfunction

   task automatic run_op(input int op, input int mode, input int vlen, input logic [DW-1:0] scal,
                         input bit poke);
      logic [DW-1:0]    ev [VLMAX];
      logic [VLMAX-1:0] em;
      int exp_cyc, k, cyc, last, bad_order, writes, diffs;
      string rq;
      em = model_mask;
      k = 0;
      for (int i = 0; i < VLMAX; i++) ev[i] = vc[i];
      for (int i = 0; i < vlen; i++) begin
         if (model_mask[i]) k++;
         if (op == 2) em[i] = ($signed(va[i]) > $signed(scal));
         else if (op < 2 && model_mask[i]) ev[i] = ref_op(op, va[i], vb[i]);
      end
      if (op == 3) em = '1;
      if (op == 3) exp_cyc = 1;
      else if (op == 2 || mode == 0) exp_cyc = vlen + 2;
      else exp_cyc = k + 2;
      rq = (op == 2) ? "R6" : (op == 3) ? "R7" : (mode == 0) ? "R2" : "R3";

      @(negedge clk);
      op_i = op[1:0]; mode_i = mode[0]; vlen_i = LEN_W'(vlen); scalar_i = scal; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      cyc = 1; last = -1; bad_order = 0; writes = 0;
      while (1) begin
         if (wr_en_o) begin
            writes++;
            if (int'(wr_idx_o) <= last || int'(wr_idx_o) >= vlen) bad_order = 1;
            last = int'(wr_idx_o);
            vc[wr_idx_o] = wr_data_o;
         end
         if (done_o || cyc > 100) break;
         if (poke && cyc == 2) begin
            op_i = 2'd3; start_i = 1'b1; // R9: clear-mask request while busy
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start_i = 1'b0;
      if (cyc > 100) check(1'b0, "watchdog", cyc, exp_cyc);
      model_mask = em;
      diffs = 0;
      for (int i = 0; i < VLMAX; i++) if (vc[i] !== ev[i]) diffs++;
      check(diffs == 0, rq, diffs, 0);
      check(mask_o === em, poke ? "R9" : rq, mask_o, em);
      check(cyc == exp_cyc, (op == 3) ? "R7" : (op == 2 || mode == 0) ? "R4" : "R5", cyc, exp_cyc);
      check(bad_order == 0, "R8", last, vlen);
      if (op >= 2 || (mode == 1 && k == 0)) check(writes == 0, (op >= 2) ? rq : "R5", writes, 0);
      @(negedge clk);
      check(done_o === 1'b0, "R10", done_o, 0);
   endtask

   task automatic fill_ops(input bit rand_vals);
      for (int i = 0; i < VLMAX; i++) begin
         if (rand_vals) begin
            va[i] = DW'($urandom);
            vb[i] = DW'($urandom);
         end else begin
            va[i] = (i % 3 == 0) ? DW'(-i - 1) : DW'(i * 7);
            vb[i] = DW'(i + 100);
         end
      end
   endtask

   initial begin
      void'($urandom(32'd475));
      for (int i = 0; i < VLMAX; i++) vc[i] = DW'(16'hC000 + i);
      model_mask = '1;
      fill_ops(1'b0);
      repeat (3) @(negedge clk);
      // R1: reset state
      check(done_o === 1'b0 && wr_en_o === 1'b0 && busy_o === 1'b0, "R1", {done_o, wr_en_o, busy_o}, 0);
      check(mask_o === '1, "R1", mask_o, 16'hFFFF);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(2, 0, 16, 16'd0, 1'b0);       // R6 compare against zero
      run_op(0, 0, 16, 16'd0, 1'b0);       // R2 masked add, full pass
      run_op(1, 1, 16, 16'd0, 1'b0);       // R3 masked multiply, skipping
      run_op(0, 0, 0, 16'd0, 1'b0);        // R4 zero length
      run_op(2, 1, 5, 16'h7FFF, 1'b0);     // R6 partial length, upper bits kept
      run_op(0, 1, 5, 16'd0, 1'b0);        // R5 no enabled bits below length
      run_op(0, 1, 16, 16'd0, 1'b1);       // R9 start while busy
      run_op(3, 0, 9, 16'd0, 1'b0);        // R7 clear mask
      run_op(1, 1, 16, 16'd0, 1'b0);       // R5 dense mask, skipping
      run_op(2, 0, 16, 16'd20, 1'b0);
      run_op(0, 1, 11, 16'd0, 1'b0);       // R3 skip with length below VLMAX

      for (int n = 0; n < 40; n++) begin
         if ($urandom % 4 == 0) fill_ops(1'b1);
         run_op(int'($urandom % 4), int'($urandom % 2), int'($urandom % (VLMAX + 1)),
                DW'($urandom), 1'b0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #200000;
      check(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule